// File: doc/BRIEF.md
# Dual-Channel Energy Pulse Output Controller

This block sits behind a metering datapath that has already multiplied voltage by current and integrated the product into energy quanta. Each of its two channels receives a one-cycle event strobe for every quantum, a flag that says whether that quantum flowed in reverse, and a flag that says whether any meaningful power is present. From these inputs it drives one pulse output and one direction output per channel, plus a shared interrupt.

A mode input picks one of two output behaviours. In fixed-width mode (mode = 0), every accepted event produces a pulse of a set length. A forward quantum gives a pulse of `ceil(71.5 us x f_clk)` cycles, and a reverse quantum gives a pulse twice that length. If an event arrives while its channel's pulse is still running, it waits in a one-deep pending slot. In latched mode (mode = 1), an accepted event makes its channel's output stick high and raises the interrupt. The output and the interrupt both stay set until software asserts the clear input. Events that arrive while the power-present flag is low are dropped, which keeps the pulse outputs quiet on an idle line.

Top module: `energy_pulse_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pulse outputs and `irq` go to 0 and both `dir_fwd` bits go to 1, whatever the inputs are.
- R2: With `mode_latched` = 0, a forward event (`ev_stb[c]` = 1, `ev_rev[c]` = 0, `pwr_ok[c]` = 1) drives `pulse_out[c]` high from the cycle after the event for exactly W cycles, where W = ceil(71.5 us x `CLK_KHZ` kHz).
- R3: With `mode_latched` = 0, a reverse event (`ev_rev[c]` = 1) produces a pulse of exactly 2W cycles.
- R4: In fixed-width mode, an event on a channel whose pulse is active is held in a one-deep pending slot, together with its own direction. After the current pulse ends, the output stays low for one cycle and then carries the pending pulse. Any further events that arrive while the slot is full are discarded.
- R5: With `mode_latched` = 1, an accepted event sets `pulse_out[c]` from the next cycle, and it stays set for as long as `irq_clr` stays low.
- R6: With `mode_latched` = 1, `irq_clr` = 1 clears both latched outputs at the next edge. This clear wins over an event in the same cycle. In fixed-width mode, `irq_clr` has no effect on the pulses.
- R7: `irq` is the OR of the two latched channel outputs. `irq` is 0 in fixed-width mode.
- R8: An event that arrives while its `pwr_ok` bit is 0 produces no pulse in either mode.
- R9: `dir_fwd[c]` equals the inverse of `ev_rev[c]` as sampled at the previous clock edge (1 = forward, 0 = reverse).
- R10: Each channel's pulse, pending slot and latched state are independent: an event on one channel leaves the other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_KHZ` kHz |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_latched | input | 1 | 0 = fixed-width pulses, 1 = latched outputs with interrupt |
| irq_clr | input | 1 | Clears latched outputs and interrupt in latched mode |
| ev_stb | input | NCH | Per-channel one-cycle energy-quantum strobe |
| ev_rev | input | NCH | Per-channel reverse-flow flag (1 = reverse) |
| pwr_ok | input | NCH | Per-channel power-present flag; 0 suppresses events |
| pulse_out | output | NCH | Per-channel pulse or latched output |
| dir_fwd | output | NCH | Per-channel direction, 1 = forward |
| irq | output | 1 | Interrupt, OR of latched channel states |

## Verification
Every result appears one edge after the stimulus that causes it. The bench drives each input on a falling edge, and the rising edge that follows samples it. So the pulse start, the latched set, the clear, `irq` and `dir_fwd` are all read at the next falling edge. Pulse length is checked by counting falling edges while the output is high. The pending case is checked by counting the single low cycle between the two pulses and then the second pulse's length. Properties inside the RTL add cycle-level checks of hold, clear priority, anti-creep and direction tracking.

// File: rtl/epc_pkg.sv
// Shared definitions for the energy pulse output controller.
// Assumes clock rates up to about 6 GHz, so the width product fits in 32 bits.
package epc_pkg;

    // Output behaviour selected by the mode input
    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_LATCH = 1'b1
    } epc_mode_e;

    // Forward pulse length in cycles: ceil(71.5 us * f), with f given in kHz
    function automatic int unsigned fwd_width(input int unsigned clk_khz);
        return (715 * clk_khz + 9999) / 10000;
    endfunction

endpackage

// File: rtl/epc_pulse_timer.sv
// Down-counter that times one fixed-width pulse.
// Loads the short or the long width on start and reports busy while nonzero.
// Assumes the caller raises start only while the timer is idle.
module epc_pulse_timer #(
    parameter int unsigned W_FWD = 15,
    parameter int unsigned W_REV = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic start,
    input  logic long_sel,
    output logic busy
);
    localparam int unsigned CW = $clog2(W_REV + 1);

    logic [CW-1:0] cnt_q;

    // Load the selected width on start, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= long_sel ? CW'(W_REV) : CW'(W_FWD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // A new pulse is only launched from idle (R4)
    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // A running pulse never stretches beyond its load without a new start (R2)
    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/epc_channel.sv
// One metering channel: anti-creep gating, fixed-width pulse with a
// one-deep pending slot, sticky latch for interrupt mode, and direction.
// Assumes ev_i is a single-cycle strobe per energy quantum.
module epc_channel #(
    parameter int unsigned W_FWD = 15,
    parameter int unsigned W_REV = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic latched_i,
    input  logic clr_i,
    input  logic ev_i,
    input  logic rev_i,
    input  logic pwr_i,
    output logic pulse_o,
    output logic dir_fwd_o,
    output logic flag_o
);
    logic acc;
    logic busy;
    logic start;
    logic long_sel;
    logic pend_q;
    logic pend_rev_q;
    logic latch_q;
    logic dir_q;

    assign acc      = ev_i && pwr_i;
    assign start    = !latched_i && !busy && (pend_q || acc);
    assign long_sel = pend_q ? pend_rev_q : rev_i;

    epc_pulse_timer #(.W_FWD(W_FWD), .W_REV(W_REV)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (latched_i),
        .start    (start),
        .long_sel (long_sel),
        .busy     (busy)
    );

    // Hold one event that arrives while a pulse is running
    always_ff @(posedge clk) begin
        if (!rst_n || latched_i) begin
            pend_q     <= 1'b0;
            pend_rev_q <= 1'b0;
        end else if (start && pend_q) begin
            pend_q     <= acc;
            pend_rev_q <= rev_i;
        end else if (acc && busy && !pend_q) begin
            pend_q     <= 1'b1;
            pend_rev_q <= rev_i;
        end
    end

    // Sticky output for latched mode; clear outranks a new event
    always_ff @(posedge clk) begin
        if (!rst_n || !latched_i) begin
            latch_q <= 1'b0;
        end else if (clr_i) begin
            latch_q <= 1'b0;
        end else if (acc) begin
            latch_q <= 1'b1;
        end
    end

    // Register the energy-flow direction, forward after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b1;
        end else begin
            dir_q <= !rev_i;
        end
    end

    assign pulse_o   = latched_i ? latch_q : busy;
    assign dir_fwd_o = dir_q;
    assign flag_o    = latch_q;

    // Latched output holds until cleared (R5)
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_i && latch_q && !clr_i) |=> latch_q);

    // Clear empties the latch even with a coincident event (R6)
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_i && clr_i) |=> !latch_q);

    // No power, no latch (R8)
    assert_creep_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_i && !latch_q && !pwr_i) |=> !latch_q);

    // No power and nothing pending keeps an idle timer idle (R8)
    assert_creep_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched_i && !busy && !pend_q && !pwr_i) |=> !busy);

    // A pending event is not lost: it stays or its pulse is running (R4)
    assert_pend_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched_i && pend_q) |=> (pend_q || busy));

    // Direction output follows the reverse flag one edge later (R9)
    assert_dir_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dir_fwd_o == !$past(rev_i)));

endmodule

// File: rtl/energy_pulse_ctrl.sv
// Top of the dual-channel energy pulse output controller.
// Instantiates one channel engine per input and merges latched states into irq.
// Assumes CLK_KHZ gives the real clock rate so that widths match 71.5 us.
module energy_pulse_ctrl #(
    parameter int unsigned CLK_KHZ = 200000,
    parameter int unsigned NCH     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_latched,
    input  logic           irq_clr,
    input  logic [NCH-1:0] ev_stb,
    input  logic [NCH-1:0] ev_rev,
    input  logic [NCH-1:0] pwr_ok,
    output logic [NCH-1:0] pulse_out,
    output logic [NCH-1:0] dir_fwd,
    output logic           irq
);
    import epc_pkg::*;

    localparam int unsigned W_FWD = fwd_width(CLK_KHZ);
    localparam int unsigned W_REV = 2 * W_FWD;

    epc_mode_e       mode;
    logic [NCH-1:0]  flag;

    assign mode = epc_mode_e'(mode_latched);

    // One independent engine per channel
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        epc_channel #(.W_FWD(W_FWD), .W_REV(W_REV)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .latched_i (mode == MODE_LATCH),
            .clr_i     (irq_clr),
            .ev_i      (ev_stb[c]),
            .rev_i     (ev_rev[c]),
            .pwr_i     (pwr_ok[c]),
            .pulse_o   (pulse_out[c]),
            .dir_fwd_o (dir_fwd[c]),
            .flag_o    (flag[c])
        );
    end

    assign irq = |flag;

    // No interrupt survives a cycle in fixed-width mode (R7)
    assert_irq_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIXED) |=> !irq);

    // Reset leaves outputs idle and direction forward (R1)
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0 && dir_fwd == '1 && flag == '0));

endmodule

// File: tb/energy_pulse_ctrl_tb_top.sv
module energy_pulse_ctrl_tb_top;
    localparam int CLK_KHZ = 200;
    localparam int WF = (715 * CLK_KHZ + 9999) / 10000;
    localparam int WR = 2 * WF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_latched = 1'b0;
    logic       irq_clr = 1'b0;
    logic [1:0] ev_stb = '0;
    logic [1:0] ev_rev = 2'b11;
    logic [1:0] pwr_ok = 2'b11;
    logic [1:0] pulse_out;
    logic [1:0] dir_fwd;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    energy_pulse_ctrl #(.CLK_KHZ(CLK_KHZ), .NCH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_latched(mode_latched), .irq_clr(irq_clr),
        .ev_stb(ev_stb), .ev_rev(ev_rev), .pwr_ok(pwr_ok),
        .pulse_out(pulse_out), .dir_fwd(dir_fwd), .irq(irq)
    );

    // vector: {mode, ch, rev, pwr, expected[11:0]}; expected = pulse length or latched level
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {4'b0001, 12'(WF)}, {4'b0011, 12'(WR)}, {4'b0101, 12'(WF)},
        {4'b0111, 12'(WR)}, {4'b0000, 12'd0},   {4'b0110, 12'd0},
        {4'b1001, 12'd1},   {4'b1111, 12'd1},   {4'b1000, 12'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input int ch, input bit rev, input bit pwr);
        @(negedge clk);
        ev_stb[ch] = 1'b1;
        ev_rev[ch] = rev;
        pwr_ok[ch] = pwr;
        @(negedge clk);
        ev_stb[ch] = 1'b0;
        pwr_ok[ch] = 1'b1;
    endtask

    task automatic run_len(input int ch, output int n);
        n = 0;
        while (pulse_out[ch] && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int n;
        int lo;
        // R1: reset with reverse flags asserted
        @(posedge clk);
        @(negedge clk);
        check(pulse_out == 2'b00, "R1 pulse", pulse_out, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(dir_fwd == 2'b11, "R1 dir", dir_fwd, 3);
        rst_n = 1'b1;
        ev_rev = 2'b00;
        idle(3);

        // table walk
        for (int v = 0; v < NV; v++) begin
            automatic bit md  = VEC[v][15];
            automatic int ch  = int'(VEC[v][14]);
            automatic bit rv  = VEC[v][13];
            automatic bit pw  = VEC[v][12];
            automatic int exp = int'(VEC[v][11:0]);
            mode_latched = md;
            idle(2);
            fire(ch, rv, pw);
            check(dir_fwd[ch] == !rv, "R9 dir", dir_fwd[ch], !rv);
            if (!md) begin
                check(pulse_out[1-ch] == 1'b0, "R10 other ch", pulse_out[1-ch], 0);
                run_len(ch, n);
                check(n == exp, pw ? (rv ? "R3 rev width" : "R2 fwd width") : "R8 creep fixed", n, exp);
                check(irq == 1'b0, "R7 irq fixed", irq, 0);
            end else begin
                check(pulse_out[ch] == exp[0], pw ? "R5 latch set" : "R8 creep latch", pulse_out[ch], exp);
                check(irq == exp[0], "R7 irq or", irq, exp);
                check(pulse_out[1-ch] == 1'b0, "R10 other ch", pulse_out[1-ch], 0);
                idle(40);
                check(pulse_out[ch] == exp[0], "R5 latch hold", pulse_out[ch], exp);
                irq_clr = 1'b1;
                @(negedge clk);
                irq_clr = 1'b0;
                check(pulse_out == 2'b00 && irq == 1'b0, "R6 clear", {irq, pulse_out}, 0);
            end
        end

        // R4: pending slot with its own direction, third event dropped
        mode_latched = 1'b0;
        idle(2);
        fire(0, 1'b0, 1'b1);
        fire(0, 1'b1, 1'b1);
        fire(0, 1'b0, 1'b1);
        check(pulse_out[1] == 1'b0, "R10 ch1 quiet", pulse_out[1], 0);
        run_len(0, n);
        lo = 0;
        while (!pulse_out[0] && lo < 50) begin
            lo++;
            @(negedge clk);
        end
        check(lo == 1, "R4 gap", lo, 1);
        run_len(0, n);
        check(n == WR, "R4 pending width", n, WR);
        lo = 0;
        for (int i = 0; i < 40; i++) begin
            if (pulse_out[0]) lo++;
            @(negedge clk);
        end
        check(lo == 0, "R4 third dropped", lo, 0);

        // R6: clear in fixed mode leaves pulse length unchanged
        fire(1, 1'b0, 1'b1);
        irq_clr = 1'b1;
        run_len(1, n);
        irq_clr = 1'b0;
        check(n == WF, "R6 clear ignored fixed", n, WF);

        // R6: clear beats coincident event, both channels cleared
        mode_latched = 1'b1;
        idle(2);
        fire(0, 1'b0, 1'b1);
        fire(1, 1'b1, 1'b1);
        check(pulse_out == 2'b11 && irq, "R5 both latched", {irq, pulse_out}, 7);
        @(negedge clk);
        irq_clr = 1'b1;
        ev_stb = 2'b11;
        @(negedge clk);
        irq_clr = 1'b0;
        ev_stb = 2'b00;
        check(pulse_out == 2'b00 && irq == 1'b0, "R6 clear priority", {irq, pulse_out}, 0);

        // R7: switching to fixed mode drops irq
        fire(0, 1'b0, 1'b1);
        mode_latched = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R7 irq after mode switch", irq, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule